// File: doc/BRIEF.md
# Reset Cause Status Flags

This block holds four sticky status flags that software reads after a restart to work out what brought the chip back. The flags are: a power-on flag, a brown-out flag, a time-out flag and a power-down flag. Each reset or power-management event arrives as a one-cycle strobe, and each event changes the flags in its own way. Software can then tell the cause apart by comparing the flag pattern with the values it wrote before the restart.

The power-on and brown-out flags are cleared only by hardware and set only by software. Each one therefore stays as evidence until software acknowledges it. The time-out and power-down flags are controlled by hardware only. The flags are read through two byte-wide views chosen by a select input. A write port updates the two software-settable flags. When strobes arrive in the same cycle, a fixed priority decides which event takes effect. A 2-bit brown-out mode input turns off the brown-out path.

Top module: `rst_cause_flags`

## Requirements
- R1: While `rst_n` is low, and after it is released, the power-on flag is 0, the brown-out flag equals the parameter `BOR_PON_VAL` (default 1), and the time-out and power-down flags are both 1.
- R2: A power-on strobe clears the power-on flag, loads `BOR_PON_VAL` into the brown-out flag and sets time-out and power-down to 1, all at the next clock edge.
- R3: A brown-out strobe with `bor_mode` not equal to 00 clears the brown-out flag and sets time-out and power-down to 1. The power-on flag keeps its value.
- R4: When `bor_mode` is 00, a brown-out strobe has no effect on any flag and does not block a software write.
- R5: A watchdog reset strobe clears time-out, leaves power-down unchanged and leaves the power-on and brown-out flags unchanged.
- R6: A watchdog wake-up strobe clears both time-out and power-down.
- R7: An external reset strobe in normal run leaves all four flags unchanged.
- R8: An external reset strobe during sleep sets time-out to 1 and clears power-down.
- R9: A sleep-entry strobe sets time-out to 1 and clears power-down. A watchdog-clear strobe sets both time-out and power-down to 1.
- R10: A write (`wr_en` high) in a cycle with no effective strobe loads `wr_data[1]` into the power-on flag and `wr_data[0]` into the brown-out flag. All other written bits are ignored. Time-out and power-down cannot be written.
- R11: A write is ignored in any cycle in which an effective strobe is present.
- R12: When several strobes arrive together, only the highest-priority one takes effect. The order, highest first, is: power-on, brown-out, watchdog reset, watchdog wake-up, external reset in run, external reset in sleep, sleep entry, watchdog clear.
- R13: With `rd_sel`=0, `rd_data` bit 0 is the brown-out flag and bit 1 is the power-on flag. With `rd_sel`=1, bit 0 is power-down and bit 1 is time-out. All higher bits read 0. The read path is combinational by default (`READ_REG`=0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, treated as a power-on |
| bor_mode | input | 2 | Brown-out enable field; 00 disables the brown-out path |
| ev_pon | input | 1 | Power-on reset strobe |
| ev_brown | input | 1 | Brown-out reset strobe |
| ev_wdt_rst | input | 1 | Watchdog reset strobe |
| ev_wdt_wake | input | 1 | Watchdog wake-up from sleep strobe |
| ev_ext_run | input | 1 | External reset during normal run strobe |
| ev_ext_sleep | input | 1 | External reset during sleep strobe |
| ev_sleep | input | 1 | Sleep entry strobe |
| ev_wdt_clr | input | 1 | Watchdog clear strobe |
| wr_en | input | 1 | Software write enable |
| wr_data | input | DATA_W | Write data; bit 1 goes to the power-on flag, bit 0 to the brown-out flag |
| rd_sel | input | 1 | Read view select: 0 power control byte, 1 status byte |
| rd_data | output | DATA_W | Read data |

## Verification
Each strobe is applied on its own, starting from a known flag pattern that software has set up. This separates the events that touch only time-out and power-down from the events that also clear a sticky flag. Writes of all-ones and of inverted data show that only two bits are captured. Writes made together with a strobe show that the event wins over software. Strobes in pairs and triples show the priority order: the pairs are chosen so that each winner leaves a pattern different from the one the loser would leave. A brown-out strobe with the mode field at 00 is also applied, both alone and together with a write.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
   localparam int unsigned RCF_NUM_EV = 8;

   // Winning event; value = strobe index + 1, so order encodes priority
   typedef enum logic [3:0] {
      EV_NONE      = 4'd0,
      EV_POR       = 4'd1,
      EV_BOR       = 4'd2,
      EV_WDT_RST   = 4'd3,
      EV_WDT_WAKE  = 4'd4,
      EV_EXT_RUN   = 4'd5,
      EV_EXT_SLEEP = 4'd6,
      EV_SLEEP     = 4'd7,
      EV_WDT_CLR   = 4'd8
   } rcf_ev_e;
endpackage

// File: rtl/rcf_arb.sv
module rcf_arb
   import rcf_pkg::*;
#(
   parameter int unsigned NUM_EV = RCF_NUM_EV
) (
   input  logic [NUM_EV-1:0] strobe_i,
   output rcf_ev_e           win_o,
   output logic              any_o
);
   if (NUM_EV != RCF_NUM_EV) begin : g_bad_num
      $error("rcf_arb: NUM_EV must match the event encoding");
   end

   // Lowest index wins: scan from the top so lower indices overwrite
   always_comb begin
      win_o = EV_NONE;
      for (int i = NUM_EV - 1; i >= 0; i--) begin
         if (strobe_i[i]) win_o = rcf_ev_e'(4'(i + 1));
      end
   end

   assign any_o = |strobe_i;
endmodule

// File: rtl/rcf_hw_flags.sv
module rcf_hw_flags
   import rcf_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  rcf_ev_e win_i,
   output logic    to_q,
   output logic    pd_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         to_q <= 1'b1;
         pd_q <= 1'b1;
      end else begin
         case (win_i)
            EV_POR, EV_BOR, EV_WDT_CLR: begin
               to_q <= 1'b1;
               pd_q <= 1'b1;
            end
            EV_WDT_RST: to_q <= 1'b0;
            EV_WDT_WAKE: begin
               to_q <= 1'b0;
               pd_q <= 1'b0;
            end
            EV_EXT_SLEEP, EV_SLEEP: begin
               to_q <= 1'b1;
               pd_q <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   p_wdt_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_i == EV_WDT_RST) |=> (!to_q && (pd_q == $past(pd_q))));

   p_ext_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (win_i == EV_EXT_RUN) |=> ($stable(to_q) && $stable(pd_q)));

   p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_i == EV_WDT_WAKE) |=> (!to_q && !pd_q));
endmodule

// File: rtl/rcf_sw_flags.sv
module rcf_sw_flags
   import rcf_pkg::*;
#(
   parameter bit BOR_PON_VAL = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  rcf_ev_e win_i,
   input  logic    wr_en_i,
   input  logic    wr_por_i,
   input  logic    wr_bor_i,
   output logic    por_q,
   output logic    bor_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         por_q <= 1'b0;
         bor_q <= BOR_PON_VAL;
      end else begin
         case (win_i)
            EV_POR: begin
               por_q <= 1'b0;
               bor_q <= BOR_PON_VAL;
            end
            EV_BOR: bor_q <= 1'b0;
            EV_NONE: begin
               if (wr_en_i) begin
                  por_q <= wr_por_i;
                  bor_q <= wr_bor_i;
               end
            end
            default: ;
         endcase
      end
   end

   p_pon_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (win_i == EV_POR) |=> (!por_q && (bor_q == BOR_PON_VAL)));

   p_wr_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && (win_i != EV_NONE) && (win_i != EV_POR) && (win_i != EV_BOR))
      |=> ($stable(por_q) && $stable(bor_q)));

   p_bor_keeps_por_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (win_i == EV_BOR) |=> (!bor_q && $stable(por_q)));
endmodule

// File: rtl/rst_cause_flags.sv
module rst_cause_flags
   import rcf_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter bit          BOR_PON_VAL = 1'b1,
   parameter int unsigned READ_REG    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bor_mode,
   input  logic              ev_pon,
   input  logic              ev_brown,
   input  logic              ev_wdt_rst,
   input  logic              ev_wdt_wake,
   input  logic              ev_ext_run,
   input  logic              ev_ext_sleep,
   input  logic              ev_sleep,
   input  logic              ev_wdt_clr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_sel,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned CTL_BOR_BIT = 0;
   localparam int unsigned CTL_POR_BIT = 1;
   localparam int unsigned ST_PD_BIT   = 0;
   localparam int unsigned ST_TO_BIT   = 1;

   if (DATA_W < 3) begin : g_bad_width
      $error("rst_cause_flags: DATA_W must be at least 3");
   end
   if (READ_REG > 1) begin : g_bad_rdmode
      $error("rst_cause_flags: READ_REG must be 0 or 1");
   end

   logic                  bor_live;
   logic                  brown_eff;
   logic [RCF_NUM_EV-1:0] strobes;
   rcf_ev_e               win;
   logic                  any_ev;
   logic                  por_q, bor_q, to_q, pd_q;
   logic [DATA_W-1:0]     ctl_word, stat_word;

   assign bor_live  = (bor_mode != 2'b00);
   assign brown_eff = ev_brown & bor_live;

   // Index order is the priority order, highest first
   assign strobes = {ev_wdt_clr, ev_sleep, ev_ext_sleep, ev_ext_run,
                     ev_wdt_wake, ev_wdt_rst, brown_eff, ev_pon};

   rcf_arb #(.NUM_EV(RCF_NUM_EV)) u_arb (
      .strobe_i (strobes),
      .win_o    (win),
      .any_o    (any_ev)
   );

   rcf_hw_flags u_hw (
      .clk   (clk),
      .rst_n (rst_n),
      .win_i (win),
      .to_q  (to_q),
      .pd_q  (pd_q)
   );

   rcf_sw_flags #(.BOR_PON_VAL(BOR_PON_VAL)) u_sw (
      .clk      (clk),
      .rst_n    (rst_n),
      .win_i    (win),
      .wr_en_i  (wr_en),
      .wr_por_i (wr_data[CTL_POR_BIT]),
      .wr_bor_i (wr_data[CTL_BOR_BIT]),
      .por_q    (por_q),
      .bor_q    (bor_q)
   );

   always_comb begin
      ctl_word              = '0;
      ctl_word[CTL_BOR_BIT] = bor_q;
      ctl_word[CTL_POR_BIT] = por_q;
      stat_word             = '0;
      stat_word[ST_PD_BIT]  = pd_q;
      stat_word[ST_TO_BIT]  = to_q;
   end

   if (READ_REG == 0) begin : g_rd_comb
      assign rd_data = rd_sel ? stat_word : ctl_word;
   end else begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= rd_sel ? stat_word : ctl_word;
      end
   end

   p_bor_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_brown && !bor_live && !wr_en &&
       !(ev_pon | ev_wdt_rst | ev_wdt_wake | ev_ext_run |
         ev_ext_sleep | ev_sleep | ev_wdt_clr))
      |=> $stable({por_q, bor_q, to_q, pd_q}));

   p_upper_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[DATA_W-1:2] == '0);

   p_pon_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_pon && any_ev) |=> (!por_q && to_q && pd_q));
endmodule

// File: tb/sim_rst_cause_flags.sv
`timescale 1ns/100ps
module sim_rst_cause_flags;
   localparam int unsigned DW  = 8;
   localparam bit          BPV = 1'b1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    bor_mode = 2'b01;
   logic [7:0]    evv = '0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_sel = 1'b0;
   logic [DW-1:0] rd_data;

   always #2 clk = ~clk;  // 250 MHz

   rst_cause_flags #(.DATA_W(DW), .BOR_PON_VAL(BPV)) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .bor_mode     (bor_mode),
      .ev_pon       (evv[0]),
      .ev_brown     (evv[1]),
      .ev_wdt_rst   (evv[2]),
      .ev_wdt_wake  (evv[3]),
      .ev_ext_run   (evv[4]),
      .ev_ext_sleep (evv[5]),
      .ev_sleep     (evv[6]),
      .ev_wdt_clr   (evv[7]),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .rd_sel       (rd_sel),
      .rd_data      (rd_data)
   );

   typedef struct {
      logic [DW-1:0] ctl;
      logic [DW-1:0] stat;
      string         tag;
   } exp_t;

   exp_t queue_q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   event sample_ev;

   // Reference flags, from the requirements
   logic m_por, m_bor, m_to, m_pd;

   function automatic exp_t mk(string tag);
      exp_t e;
      e.ctl  = '0; e.ctl[1]  = m_por; e.ctl[0]  = m_bor;
      e.stat = '0; e.stat[1] = m_to;  e.stat[0] = m_pd;
      e.tag  = tag;
      return e;
   endfunction

   function automatic void model(logic [7:0] s, logic [1:0] mode,
                                 logic we, logic [DW-1:0] wd);
      logic brown;
      brown = s[1] && (mode != 2'b00);
      if (s[0]) begin m_por = 0; m_bor = BPV; m_to = 1; m_pd = 1; end
      else if (brown) begin m_bor = 0; m_to = 1; m_pd = 1; end
      else if (s[2]) m_to = 0;
      else if (s[3]) begin m_to = 0; m_pd = 0; end
      else if (s[4]) ;
      else if (s[5]) begin m_to = 1; m_pd = 0; end
      else if (s[6]) begin m_to = 1; m_pd = 0; end
      else if (s[7]) begin m_to = 1; m_pd = 1; end
      else if (we) begin m_por = wd[1]; m_bor = wd[0]; end
   endfunction

   // Driver: apply one cycle of stimulus, push expectation
   task automatic step(string tag, logic [7:0] s, logic [1:0] mode,
                       logic we, logic [DW-1:0] wd);
      @(negedge clk);
      evv = s; bor_mode = mode; wr_en = we; wr_data = wd;
      model(s, mode, we, wd);
      queue_q.push_back(mk(tag));
      @(posedge clk);
      #1;
      evv = '0; wr_en = 1'b0; wr_data = '0;
      -> sample_ev;
   endtask

   // Monitor: read both views and compare against the queue head
   initial begin
      forever begin
         logic [DW-1:0] got_c, got_s;
         exp_t e;
         @(sample_ev);
         rd_sel = 1'b0; #0.2; got_c = rd_data;
         rd_sel = 1'b1; #0.2; got_s = rd_data;
         rd_sel = 1'b0;
         if (queue_q.size() == 0) begin
            errors++;
            $display("FAIL monitor: empty queue got ctl %h stat %h exp none", got_c, got_s);
         end else begin
            e = queue_q.pop_front();
            checks++;
            if (got_c !== e.ctl || got_s !== e.stat) begin
               errors++;
               $display("FAIL %s: ctl %h stat %h, expected ctl %h stat %h",
                        e.tag, got_c, got_s, e.ctl, e.stat);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run incomplete, got hang expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      m_por = 0; m_bor = BPV; m_to = 1; m_pd = 1;
      // R1 during reset
      #3;
      checks++;
      rd_sel = 1'b0; #0.2;
      if (rd_data !== 8'h01) begin
         errors++;
         $display("FAIL R1 in reset: ctl %h expected %h", rd_data, 8'h01);
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step("R1 after release", 8'h00, 2'b01, 0, '0);
      step("R10 write 03",       8'h00, 2'b01, 1, 8'h03);
      step("R10 R13 write FC",   8'h00, 2'b01, 1, 8'hFC);
      step("R10 write 03 again", 8'h00, 2'b01, 1, 8'h03);
      step("R3 brown-out",       8'h02, 2'b01, 0, '0);
      step("R10 restore",        8'h00, 2'b10, 1, 8'h03);
      step("R4 brown disabled",  8'h02, 2'b00, 0, '0);
      step("R4 brown disabled with write", 8'h02, 2'b00, 1, 8'h01);
      step("R10 restore 2",      8'h00, 2'b01, 1, 8'h03);
      step("R9 sleep",           8'h40, 2'b01, 0, '0);
      step("R6 wdt wake",        8'h08, 2'b01, 0, '0);
      step("R9 wdt clear",       8'h80, 2'b01, 0, '0);
      step("R5 wdt reset",       8'h04, 2'b01, 0, '0);
      step("R8 ext in sleep",    8'h20, 2'b01, 0, '0);
      step("R7 ext in run",      8'h10, 2'b01, 0, '0);
      step("R11 write with sleep", 8'h40, 2'b01, 1, 8'h00);
      step("R11 write with wdt clear", 8'h80, 2'b11, 1, 8'h00);
      step("R2 power-on",        8'h01, 2'b01, 0, '0);
      step("R10 set both",       8'h00, 2'b01, 1, 8'h03);
      step("R12 wdt rst over wake/ext", 8'h2C, 2'b01, 0, '0);
      step("R12 pon over brown", 8'h03, 2'b01, 0, '0);
      step("R10 set both 2",     8'h00, 2'b01, 1, 8'h03);
      step("R12 brown over sleep", 8'h42, 2'b01, 0, '0);
      step("R12 ext run over sleep", 8'h50, 2'b01, 0, '0);
      step("R12 wake over clear", 8'h88, 2'b01, 0, '0);
      step("R12 sleep over clear", 8'hC0, 2'b01, 0, '0);
      repeat (2) @(posedge clk);
      #1;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule